// File: doc/BRIEF.md
# Register-Launched Two-Wire Bus Master

This block is a two-wire (I2C) bus master for setting up a video decoder over its serial control bus. Software, or a state machine acting for it, loads a target device address, a register index inside that device and a data byte into a small register bank. Writing the data register sends one byte to the indexed register. Setting the read-launch bit in the control register fetches one byte from the indexed register. The fetched byte comes back through the same data register.

A read always sends the register index first and then turns the bus around to receive. A control bit picks how the turnaround is done. It can be a single combined transfer that uses a repeated START. It can also be two separate transfers: the first ends in a STOP after the index, and the second opens with a fresh START. The block produces SCL from a clock divider, drives SDA only low (open drain), checks every acknowledge slot and shows a busy flag while a transfer runs. A refused byte ends the transfer at once with a STOP and sets a sticky error flag.

Top module: `i2cSeqMaster`

## Requirements
- R1: After reset, the device-address, index and data registers read 0x00, the status register reads 0x00, SCL is high and SDA is released.
- R2: The register offsets are: 0 device address, 1 register index, 2 data, 3 control, 4 status. Control bit 1 selects the read turnaround (1 = repeated START, 0 = STOP then START), is stored and reads back. Control bit 0 is the read-launch bit and always reads 0. Status bit 0 is busy and status bit 1 is error. Any other offset reads 0x00.
- R3: A write to offset 2 while idle stores the byte and sends this sequence: START, address byte, index byte, data byte, STOP. Each byte is followed by an acknowledge slot. The address byte is device-address bits 7..1 followed by a 0 direction bit.
- R4: A write of 1 to control bit 0 while idle, with bit 1 = 1, sends this sequence: START, address byte with direction 0, index byte, repeated START, address byte with direction 1 (device-address bits 7..1 then 1), one received byte, STOP.
- R5: The same launch with bit 1 = 0 sends START, address byte with direction 0, index byte, STOP, and then START, address byte with direction 1, one received byte, STOP.
- R6: After the received byte the master leaves SDA high in the acknowledge slot (NACK) before the STOP, and the byte can then be read at offset 2.
- R7: Busy reads 1 from the clock cycle after the launching write until the final STOP is complete, and 0 otherwise.
- R8: While SCL is high during address or data bits, SDA stays constant. SDA changes under high SCL only to form START and STOP. One SCL bit period lasts 4 × QUARTER_CLKS clock cycles.
- R9: If SDA is high in an acknowledge slot that the target should drive, the master goes straight to a STOP and sets the error flag. The flag stays set until the next transfer is launched, and is cleared at that launch.
- R10: Register writes that arrive while busy is 1 change no register and launch nothing.
- R11: When idle, SCL is driven high and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset for the write and the readback |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Readback of the register at regAddr |
| busy | output | 1 | A transfer is in progress |
| sclOut | output | 1 | Serial clock level |
| sdaLowEn | output | 1 | 1 pulls SDA low, 0 releases it |
| sdaIn | input | 1 | Level sensed on the SDA line |

## Verification
The bench builds the block with QUARTER_CLKS = 3. This gives a 12-cycle SCL bit. Many complete transfers then fit in a short run, and the divider must wrap at a count that is not a power of two. At this setting a bus-level target model can log every START, STOP and byte with its acknowledge level. Its refusals can be placed on the address, index, data or read-address byte, including the second transfer of a split read. Address bytes with bit 0 already set, and the extreme data values 0x00 and 0xFF, show that the direction bit and the received byte are handled correctly.

// File: rtl/i2cSeqPkg.sv
package i2cSeqPkg;
  localparam logic [2:0] OFS_SLAVE  = 3'd0;
  localparam logic [2:0] OFS_SUB    = 3'd1;
  localparam logic [2:0] OFS_DATA   = 3'd2;
  localparam logic [2:0] OFS_CTRL   = 3'd3;
  localparam logic [2:0] OFS_STATUS = 3'd4;

  typedef enum logic [1:0] {SK_IDLE, SK_START, SK_BIT, SK_STOP} slotKind_e;
  typedef enum logic [2:0] {LB_ADDRW, LB_SUB, LB_DATA, LB_ADDRR, LB_ONES} loadSel_e;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDRW, ST_SUB, ST_WDATA,
    ST_MIDSTOP, ST_RESTART, ST_ADDRR, ST_RDATA, ST_STOP
  } seqState_e;

  typedef struct packed {
    slotKind_e kind;
    logic      load;
    loadSel_e  sel;
    logic      capture;
    logic      setErr;
    logic      clrErr;
  } seqStrobes_t;
endpackage

// File: rtl/i2cSeqDatapath.sv
module i2cSeqDatapath
  import i2cSeqPkg::*;
#(
  parameter int QUARTER_CLKS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic        busy,
  input  seqStrobes_t stb,
  output logic        goWrite,
  output logic        goRead,
  output logic        rsSel,
  output logic        slotDone,
  output logic        lastBit,
  output logic        ackNack,
  output logic        errFlag,
  output logic        sclOut,
  output logic        sdaLowEn,
  input  logic        sdaIn
);
  localparam int DW = (QUARTER_CLKS > 1) ? $clog2(QUARTER_CLKS) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(QUARTER_CLKS - 1);

  logic [7:0]    slaveReg, subReg, dataReg, txShift, rxShift;
  logic          rsSelReg, errReg, ackReg;
  logic [DW-1:0] divCnt;
  logic [1:0]    quarter;
  logic [3:0]    bitCnt;
  logic          active, tick, sampleTick, wrOk, sdaVal;

  assign active     = stb.kind != SK_IDLE;
  assign tick       = active && (divCnt == DIV_LAST);
  assign sampleTick = tick && (quarter == 2'd1);
  assign slotDone   = tick && (quarter == 2'd3);
  assign lastBit    = bitCnt == 4'd8;
  assign wrOk       = regWe && !busy;
  assign goWrite    = wrOk && (regAddr == OFS_DATA);
  assign goRead     = wrOk && (regAddr == OFS_CTRL) && regWdata[0];
  assign rsSel      = rsSelReg;
  assign ackNack    = ackReg;
  assign errFlag    = errReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slaveReg <= '0; subReg <= '0; dataReg <= '0;
      rsSelReg <= 1'b0; errReg <= 1'b0; ackReg <= 1'b1;
      txShift <= '1; rxShift <= '0;
      divCnt <= '0; quarter <= '0; bitCnt <= '0;
    end else begin
      if (wrOk) begin
        case (regAddr)
          OFS_SLAVE: slaveReg <= regWdata;
          OFS_SUB:   subReg   <= regWdata;
          OFS_DATA:  dataReg  <= regWdata;
          OFS_CTRL:  rsSelReg <= regWdata[1];
          default: ;
        endcase
      end
      if (stb.capture) dataReg <= rxShift;
      if (stb.clrErr) errReg <= 1'b0;
      else if (stb.setErr) errReg <= 1'b1;

      if (!active || tick) divCnt <= '0;
      else divCnt <= divCnt + 1'b1;

      if (!active) quarter <= '0;
      else if (tick) quarter <= quarter + 2'd1;

      if (stb.kind != SK_BIT) bitCnt <= '0;
      else if (slotDone) bitCnt <= lastBit ? 4'd0 : bitCnt + 4'd1;

      if (stb.load) begin
        case (stb.sel)
          LB_ADDRW: txShift <= {slaveReg[7:1], 1'b0};
          LB_SUB:   txShift <= subReg;
          LB_DATA:  txShift <= dataReg;
          LB_ADDRR: txShift <= {slaveReg[7:1], 1'b1};
          default:  txShift <= 8'hFF;
        endcase
      end else if (slotDone && stb.kind == SK_BIT && !lastBit) begin
        txShift <= {txShift[6:0], 1'b1};
      end

      if (sampleTick && stb.kind == SK_BIT) begin
        if (lastBit) ackReg <= sdaIn;
        else rxShift <= {rxShift[6:0], sdaIn};
      end
    end
  end

  // Line levels per quarter of the current slot
  always_comb begin
    case (stb.kind)
      SK_START: begin sclOut = quarter[0] ^ quarter[1]; sdaVal = !quarter[1]; end
      SK_BIT:   begin sclOut = quarter[0] ^ quarter[1]; sdaVal = lastBit ? 1'b1 : txShift[7]; end
      SK_STOP:  begin sclOut = quarter != 2'd0; sdaVal = quarter[1]; end
      default:  begin sclOut = 1'b1; sdaVal = 1'b1; end
    endcase
  end
  assign sdaLowEn = !sdaVal;

  always_comb begin
    case (regAddr)
      OFS_SLAVE:  regRdata = slaveReg;
      OFS_SUB:    regRdata = subReg;
      OFS_DATA:   regRdata = dataReg;
      OFS_CTRL:   regRdata = {6'b0, rsSelReg, 1'b0};
      OFS_STATUS: regRdata = {6'b0, errReg, busy};
      default:    regRdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/i2cSeqControl.sv
module i2cSeqControl
  import i2cSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        goWrite,
  input  logic        goRead,
  input  logic        rsSel,
  input  logic        slotDone,
  input  logic        lastBit,
  input  logic        ackNack,
  output logic        busy,
  output seqStrobes_t stb
);
  seqState_e state, nxt;
  logic      isRead, byteEnd;

  assign byteEnd = slotDone && lastBit;
  assign busy    = state != ST_IDLE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      isRead <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && (goWrite || goRead)) isRead <= goRead;
    end
  end

  always_comb begin
    nxt         = state;
    stb.load    = 1'b0;
    stb.sel     = LB_ONES;
    stb.capture = 1'b0;
    stb.setErr  = 1'b0;
    stb.clrErr  = 1'b0;
    case (state)
      ST_START, ST_RESTART:  stb.kind = SK_START;
      ST_MIDSTOP, ST_STOP:   stb.kind = SK_STOP;
      ST_IDLE:               stb.kind = SK_IDLE;
      default:               stb.kind = SK_BIT;
    endcase
    case (state)
      ST_IDLE: if (goWrite || goRead) begin nxt = ST_START; stb.clrErr = 1'b1; end
      ST_START: if (slotDone) begin nxt = ST_ADDRW; stb.load = 1'b1; stb.sel = LB_ADDRW; end
      ST_ADDRW: if (byteEnd) begin
        if (ackNack) begin nxt = ST_STOP; stb.setErr = 1'b1; end
        else begin nxt = ST_SUB; stb.load = 1'b1; stb.sel = LB_SUB; end
      end
      ST_SUB: if (byteEnd) begin
        if (ackNack) begin nxt = ST_STOP; stb.setErr = 1'b1; end
        else if (!isRead) begin nxt = ST_WDATA; stb.load = 1'b1; stb.sel = LB_DATA; end
        else nxt = rsSel ? ST_RESTART : ST_MIDSTOP;
      end
      ST_WDATA: if (byteEnd) begin nxt = ST_STOP; stb.setErr = ackNack; end
      ST_MIDSTOP: if (slotDone) nxt = ST_RESTART;
      ST_RESTART: if (slotDone) begin nxt = ST_ADDRR; stb.load = 1'b1; stb.sel = LB_ADDRR; end
      ST_ADDRR: if (byteEnd) begin
        if (ackNack) begin nxt = ST_STOP; stb.setErr = 1'b1; end
        else begin nxt = ST_RDATA; stb.load = 1'b1; stb.sel = LB_ONES; end
      end
      ST_RDATA: if (byteEnd) begin nxt = ST_STOP; stb.capture = 1'b1; end
      ST_STOP: if (slotDone) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/i2cSeqMaster.sv
module i2cSeqMaster
  import i2cSeqPkg::*;
#(
  parameter int QUARTER_CLKS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       busy,
  output logic       sclOut,
  output logic       sdaLowEn,
  input  logic       sdaIn
);
  seqStrobes_t stb;
  slotKind_e   curKind;
  logic goWrite, goRead, rsSel, slotDone, lastBit, ackNack, errFlag;

  assign curKind = stb.kind;

  i2cSeqControl i_ctrl (
    .clk(clk), .rstN(rstN), .goWrite(goWrite), .goRead(goRead), .rsSel(rsSel),
    .slotDone(slotDone), .lastBit(lastBit), .ackNack(ackNack), .busy(busy), .stb(stb)
  );

  i2cSeqDatapath #(.QUARTER_CLKS(QUARTER_CLKS)) i_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .busy(busy), .stb(stb), .goWrite(goWrite), .goRead(goRead),
    .rsSel(rsSel), .slotDone(slotDone), .lastBit(lastBit), .ackNack(ackNack),
    .errFlag(errFlag), .sclOut(sclOut), .sdaLowEn(sdaLowEn), .sdaIn(sdaIn)
  );
endmodule

// File: rtl/i2cSeqChecker.sv
module i2cSeqChecker
  import i2cSeqPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       regWe,
  input logic [2:0] regAddr,
  input logic       busy,
  input logic       sclOut,
  input logic       sdaLowEn,
  input slotKind_e  kind,
  input logic       errFlag
);
  a_r11_idle_release: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclOut && !sdaLowEn));

  a_r8_sda_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (kind == SK_BIT && $past(kind) == SK_BIT && sclOut && $past(sclOut)) |-> $stable(sdaLowEn));

  a_r7_busy_on_launch: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !busy && regAddr == OFS_DATA) |=> busy);

  a_r7_busy_ends_in_stop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(kind) == SK_STOP));

  a_r9_err_with_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> (kind == SK_STOP));
endmodule

bind i2cSeqMaster i2cSeqChecker i_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .busy(busy),
  .sclOut(sclOut), .sdaLowEn(sdaLowEn), .kind(curKind), .errFlag(errFlag)
);

// File: tb/test_i2cSeqMaster.sv
`timescale 1ns/1ps
module test_i2cSeqMaster;
  localparam int QC = 3;
  localparam logic [15:0] TK_S = 16'h1000;
  localparam logic [15:0] TK_P = 16'h2000;
  // {op, device address, index, data, refused byte (7 = none)}; op 0 write, 1 combined read, 2 split read
  localparam logic [28:0] VEC [9] = '{
    {2'd0, 8'h4A, 8'h10, 8'h5C, 3'd7},
    {2'd0, 8'h4B, 8'hFF, 8'h00, 3'd7},
    {2'd1, 8'h4A, 8'h03, 8'hA5, 3'd7},
    {2'd2, 8'h30, 8'h80, 8'h3C, 3'd7},
    {2'd1, 8'hFE, 8'h00, 8'hFF, 3'd7},
    {2'd0, 8'h4A, 8'h11, 8'h77, 3'd0},
    {2'd0, 8'h22, 8'h12, 8'h99, 3'd2},
    {2'd1, 8'h42, 8'h44, 8'h55, 3'd1},
    {2'd2, 8'h42, 8'h45, 8'h66, 3'd2}
  };

  logic clk = 0, rstN = 0, regWe = 0;
  logic [2:0] regAddr = 0;
  logic [7:0] regWdata = 0, regRdata;
  logic busy, sclOut, sdaLowEn;
  logic slaveLow = 0;
  wire  sdaLine = !(sdaLowEn || slaveLow);

  int nChecks = 0, nBad = 0, cyc = 0;
  int bitIdx = 0, byteNo = 0, seqByte = 0, nackIdx = 7, logN = 0, expN = 0;
  int lastRise = 0, periodSeen = 0, periodBad = 0;
  bit active = 0, rdMode = 0, ackGiven = 0;
  logic [7:0] rx = 0, rdByte = 0, shadowData = 0;
  logic [15:0] logT [16];
  logic [15:0] expT [16];

  i2cSeqMaster #(.QUARTER_CLKS(QC)) i_i2cSeqMaster (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .busy(busy), .sclOut(sclOut), .sdaLowEn(sdaLowEn), .sdaIn(sdaLine)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  // Bus-level target model
  always @(negedge sdaLine) if (sclOut === 1'b1) begin
    if (logN < 16) logT[logN] = TK_S;
    logN++; active = 1; bitIdx = 0; byteNo = 0; rdMode = 0; slaveLow = 0;
  end
  always @(posedge sdaLine) if (sclOut === 1'b1 && active) begin
    if (logN < 16) logT[logN] = TK_P;
    logN++; active = 0; slaveLow = 0;
  end
  always @(posedge sclOut) if (active) begin
    if (bitIdx >= 1 && bitIdx <= 8) begin
      periodSeen++;
      if (cyc - lastRise != 4 * QC) periodBad++;
    end
    lastRise = cyc;
    if (bitIdx < 8) rx = {rx[6:0], sdaLine};
    else begin
      if (logN < 16) logT[logN] = {4'h3, 3'b0, sdaLine, rx};
      logN++;
    end
    bitIdx++;
  end
  always @(negedge sclOut) if (active) begin
    if (bitIdx == 8) begin
      if (byteNo == 0) rdMode = rx[0];
      if (byteNo == 0 || !rdMode) begin
        ackGiven = (seqByte != nackIdx); slaveLow = ackGiven;
      end else slaveLow = 0;
    end else if (bitIdx == 9) begin
      slaveLow = 0; bitIdx = 0; byteNo++; seqByte++;
      if (rdMode && byteNo == 1 && ackGiven) slaveLow = !rdByte[7];
    end else if (rdMode && byteNo == 1 && ackGiven && bitIdx >= 1 && bitIdx < 8)
      slaveLow = !rdByte[7 - bitIdx];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; #1 v = regRdata;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk(!busy, tag, busy, 0);
  endtask

  task automatic pushT(input logic [15:0] t);
    expT[expN] = t; expN++;
  endtask

  task automatic buildExp(input logic [1:0] op, input logic [7:0] sl, input logic [7:0] sb,
                          input logic [7:0] d, input logic [2:0] nk);
    expN = 0;
    pushT(TK_S);
    pushT({4'h3, 3'b0, nk == 0, sl[7:1], 1'b0});
    if (nk == 0) begin pushT(TK_P); return; end
    pushT({4'h3, 3'b0, nk == 1, sb});
    if (nk == 1) begin pushT(TK_P); return; end
    if (op == 0) begin
      pushT({4'h3, 3'b0, nk == 2, d}); pushT(TK_P); return;
    end
    if (op == 2) pushT(TK_P);
    pushT(TK_S);
    pushT({4'h3, 3'b0, nk == 2, sl[7:1], 1'b1});
    if (nk == 2) begin pushT(TK_P); return; end
    pushT({4'h3, 3'b0, 1'b1, d});
    pushT(TK_P);
  endtask

  task automatic cmpLog(input string tag);
    bit ok = (logN == expN);
    int bad = -1;
    for (int i = 0; i < expN && i < 16; i++)
      if (bad < 0 && logT[i] !== expT[i]) bad = i;
    if (bad >= 0) chk(0, tag, logT[bad], expT[bad]);
    else chk(ok, tag, logN, expN);
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rstN = 1;
    // R1 / R11: reset state
    for (int a = 0; a < 5; a++) begin
      regRead(3'(a), v);
      chk(v == 8'h00, "R1 reset register", v, 0);
    end
    chk(sclOut === 1'b1 && sdaLowEn === 1'b0, "R11 idle lines", {sclOut, sdaLowEn}, 2'b10);
    regRead(3'd6, v);
    chk(v == 8'h00, "R2 unused offset", v, 0);

    // Vector table
    for (int k = 0; k < 9; k++) begin
      logic [1:0] op; logic [7:0] sl, sb, d; logic [2:0] nk;
      {op, sl, sb, d, nk} = VEC[k];
      nackIdx = (nk == 7) ? 7 : int'(nk);
      rdByte = d; seqByte = 0; logN = 0;
      regWrite(OFS_SLAVE_B, sl);
      regWrite(3'd1, sb);
      if (op == 0) begin regWrite(3'd2, d); shadowData = d; end
      else regWrite(3'd3, {6'b0, op == 2'd1, 1'b1});
      chk(busy === 1'b1, "R7 busy after launch", busy, 1);
      waitIdle("R7 transfer ends");
      buildExp(op, sl, sb, d, nk);
      cmpLog(op == 0 ? (nk == 7 ? "R3 write sequence" : "R9 write abort")
                     : (nk != 7 ? "R9 read abort" : (op == 1 ? "R4 combined read" : "R5 split read")));
      if (op != 0 && nk == 7) shadowData = d;
      regRead(3'd2, v);
      chk(v == shadowData, "R6 data register", v, shadowData);
      regRead(3'd4, v);
      chk(v == {6'b0, nk != 7, 1'b0}, "R9 status error", v, {6'b0, nk != 7, 1'b0});
      regRead(3'd3, v);
      if (op != 0) chk(v == {6'b0, op == 2'd1, 1'b0}, "R2 control readback", v, {6'b0, op == 2'd1, 1'b0});
    end

    // R9: error stays set, then clears at the next launch
    repeat (20) @(negedge clk);
    regRead(3'd4, v);
    chk(v[1] == 1'b1, "R9 error sticky", v[1], 1);
    logN = 0; seqByte = 0; nackIdx = 7;
    regWrite(3'd0, 8'h4A);
    regWrite(3'd1, 8'h01);
    regWrite(3'd2, 8'h12);
    regRead(3'd4, v);
    chk(v == 8'h01, "R9 error cleared at launch", v, 8'h01);
    // R10: writes during busy are ignored
    regWrite(3'd0, 8'h00);
    regWrite(3'd1, 8'h99);
    regWrite(3'd2, 8'hEE);
    regWrite(3'd3, 8'h01);
    waitIdle("R10 transfer ends");
    repeat (10) @(negedge clk);
    chk(busy === 1'b0, "R10 no second launch", busy, 0);
    buildExp(2'd0, 8'h4A, 8'h01, 8'h12, 3'd7);
    cmpLog("R10 sequence unaffected");
    regRead(3'd0, v); chk(v == 8'h4A, "R10 address kept", v, 8'h4A);
    regRead(3'd1, v); chk(v == 8'h01, "R10 index kept", v, 8'h01);
    regRead(3'd2, v); chk(v == 8'h12, "R10 data kept", v, 8'h12);
    regRead(3'd3, v); chk(v == 8'h00, "R10 control kept", v, 8'h00);

    // R2: select bit without launch bit only stores
    regWrite(3'd3, 8'h02);
    chk(busy === 1'b0, "R2 no launch from bit 1", busy, 0);
    regRead(3'd3, v);
    chk(v == 8'h02, "R2 select readback", v, 8'h02);

    // R8: SCL bit period
    chk(periodSeen > 0 && periodBad == 0, "R8 scl period", periodBad, 0);
    chk(sclOut === 1'b1 && sdaLowEn === 1'b0, "R11 idle after transfers", {sclOut, sdaLowEn}, 2'b10);

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  localparam logic [2:0] OFS_SLAVE_B = 3'd0;

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nBad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule